// File: doc/BRIEF.md
# SPI Register-Access Target

This block is an SPI target that gives a host access to a small register file. The host pulls chip select low and sends an opcode byte first. The opcode holds a fixed five-bit prefix, two bits that must match the target's strap pins, and a read/write flag. The host then sends a register address byte, followed by any number of data bytes. On a write, each complete data byte appears as a single write pulse on a simple register bus. On a read, the bus is strobed and the returned byte is shifted out on SO, most significant bit first.

Up to four targets can share one chip select because the opcode carries the strap bits. An address pointer picks the register for each data byte. By default the pointer steps forward after every byte and wraps at the end of the file. A hold input pins the pointer so that one register can be polled or rewritten repeatedly. The SPI lines are sampled by the system clock, so SCK must be several times slower than that clock.

Top module: `spi_regport`

## Requirements
- R1: After reset no bus strobe is issued, spi_so_oe is 0, and the target waits for an opcode. Whenever spi_cs_n is high the target returns to waiting for an opcode.
- R2: The bus uses SPI mode 0 with the MSB first. SI is sampled on rising SCK. The opcode bits, from MSB to LSB, are 0,1,0,0,0, then A1, A0, then R/W, where R/W = 1 means read.
- R3: If the opcode's address bits differ from hw_addr, or its prefix is wrong, the target issues no write or read strobe and keeps spi_so_oe low until chip select rises.
- R4: In a write, each complete data byte gives exactly one reg_wr pulse, with reg_wdata set to that byte and reg_addr set to the current pointer.
- R5: In a read, each data byte shifted out on spi_so is the reg_rdata value at the current pointer, MSB first. SO changes after falling SCK edges.
- R6: With ptr_hold low, the pointer advances by one after each data byte, and the next address after NREGS-1 (10) is 0.
- R7: With ptr_hold high, the pointer stays at the address byte's value, so every data byte reads or writes the same register.
- R8: A data byte that is still incomplete when chip select rises produces no write.
- R9: spi_so_oe is high only while chip select is low during the data phase of a matched read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_addr | input | 2 | Strap address bits compared with opcode bits 2:1 |
| ptr_hold | input | 1 | 1 holds the address pointer, 0 lets it advance |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so |
| reg_addr | output | 8 | Register bus address (the pointer) |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is taken in that cycle |
| reg_rdata | input | 8 | Read data, combinational from reg_addr |

## Verification
Each SPI line goes through a two-flop synchronizer and one edge-detect stage. A write strobe therefore arrives about four system clocks after the eighth rising SCK of a byte. The next read byte is fetched about four clocks later, and SO moves about three clocks after each falling SCK. The bench holds each SCK level for ten system clocks. It samples SO just before every rising edge and checks register contents only after chip select has risen and settled, so every result has arrived well before it is compared.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int NREGS = 11,
  parameter logic [4:0] OPC_FIXED = 5'b01000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hw_addr,
  input  logic       ptr_hold,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_si,
  output logic       spi_so,
  output logic       spi_so_oe,
  output logic [7:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata
);
  localparam logic [7:0] LAST = 8'(NREGS - 1);

  typedef enum logic [1:0] {PH_OPC, PH_ADR, PH_DATA, PH_SKIP} phase_t;

  logic [1:0] cs_p, si_p;
  logic [2:0] sck_p;
  phase_t     phase;
  logic [2:0] cnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, so_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= 2'b11;
      si_p  <= '0;
      sck_p <= '0;
    end else begin
      cs_p  <= {cs_p[0], spi_cs_n};
      si_p  <= {si_p[0], spi_si};
      sck_p <= {sck_p[1:0], spi_sck};
    end

  wire       cs_hi     = cs_p[1];
  wire       sck_rise  = sck_p[1] & ~sck_p[2] & ~cs_hi;
  wire       sck_fall  = ~sck_p[1] & sck_p[2] & ~cs_hi;
  wire [7:0] byte_in   = {sh[6:0], si_p[1]};
  wire       op_match  = (byte_in[7:3] == OPC_FIXED) && (byte_in[2:1] == hw_addr);
  wire [7:0] ptr_next  = ptr_hold ? ptr : (ptr >= LAST ? 8'd0 : ptr + 8'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_OPC;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      so_q      <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (reg_rd) tx <= reg_rdata;
      if (reg_wr) ptr <= ptr_next;
      if (cs_hi) begin
        phase <= PH_OPC;
        cnt   <= '0;
      end else begin
        if (sck_rise && phase != PH_SKIP) begin
          sh  <= byte_in;
          cnt <= cnt + 3'd1;
          if (cnt == 3'd7)
            case (phase)
              PH_OPC:
                if (op_match) begin
                  rw    <= byte_in[0];
                  phase <= PH_ADR;
                end else
                  phase <= PH_SKIP;
              PH_ADR: begin
                ptr    <= byte_in;
                reg_rd <= rw;
                phase  <= PH_DATA;
              end
              PH_DATA:
                if (rw) begin
                  ptr    <= ptr_next;
                  reg_rd <= 1'b1;
                end else begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= byte_in;
                end
              default: ;
            endcase
        end
        if (sck_fall && phase == PH_DATA && rw) begin
          so_q <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end

  assign reg_addr  = ptr;
  assign spi_so    = so_q;
  assign spi_so_oe = ~cs_hi & (phase == PH_DATA) & rw;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R4
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_SKIP |-> !reg_wr && !reg_rd && !spi_so_oe); // R3
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) cs_hi |=> phase == PH_OPC); // R1
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) reg_wr && !ptr_hold && ptr == LAST |=> ptr == 8'd0); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) reg_wr && ptr_hold |=> $stable(ptr)); // R7
  AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n) spi_so_oe |-> rw && !spi_cs_n || $rose(spi_cs_n) || cs_p[0]); // R9
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] hw_addr = 2'b10;
  logic ptr_hold = 0, sck = 0, cs_n = 1, si = 0;
  logic so, so_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [11];
  logic [7:0] expv [11];
  int checks = 0, fails = 0, wrcnt = 0, rdcnt = 0;
  logic oe_seen;

  always #2 clk = ~clk;

  spi_regport uut (.clk(clk), .rst_n(rst_n), .hw_addr(hw_addr), .ptr_hold(ptr_hold),
    .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si), .spi_so(so), .spi_so_oe(so_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata));

  assign reg_rdata = (reg_addr < 8'd11) ? mem[reg_addr] : 8'h00;

  always @(posedge clk) begin
    if (reg_wr) begin
      wrcnt++;
      if (reg_wdata !== 8'hxx && reg_addr < 8'd11) mem[reg_addr] <= reg_wdata;
    end
    if (reg_rd) rdcnt++;
    if (so_oe) oe_seen = 1;
  end

  function automatic logic [7:0] step(input logic [7:0] p, input logic hold);
    if (hold) return p;
    return (p >= 8'd10) ? 8'd0 : p + 8'd1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 0;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      #36 rx[i] = so;
      #4 sck = 1;
      #40 sck = 0;
    end
  endtask

  task automatic txn(input logic [1:0] a, input bit rd, input logic [7:0] addr,
                     input int n, input bit hold, input bit partial);
    logic [7:0] rx, p, d;
    bit match;
    int w0;
    match = (a == hw_addr);
    ptr_hold = hold;
    oe_seen = 0;
    w0 = wrcnt;
    cs_n = 0;
    #40;
    xfer({5'b01000, a, rd}, 8, rx);
    xfer(addr, 8, rx);
    p = addr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xfer(d, 8, rx);
      if (match && rd) check(rx == expv[p], "R5", rx, expv[p]);
      if (match && !rd) expv[p] = d;
      p = step(p, hold);
    end
    if (partial) xfer(8'hA5, 4, rx);
    #20 cs_n = 1;
    #100;
    if (!match) begin
      check(wrcnt == w0, "R3", wrcnt - w0, 0);
      check(!oe_seen, "R3", oe_seen, 0);
    end else if (rd) check(oe_seen && so_oe == 0, "R9", oe_seen, 1);
    else check(wrcnt - w0 == n, partial ? "R8" : "R4", wrcnt - w0, n);
    for (int r = 0; r < 11; r++)
      check(mem[r] == expv[r], hold ? "R7" : "R6", mem[r], expv[r]);
  endtask

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 11; r++) begin mem[r] = 0; expv[r] = 0; end
    #20 rst_n = 1;
    #20;
    check(!so_oe && !reg_wr && !reg_rd, "R1", {so_oe, reg_wr, reg_rd}, 0);
    check(reg_addr == 0, "R1", reg_addr, 0);
    txn(2'b10, 0, 8'd9, 4, 0, 0);   // R6 wrap 9,10,0,1
    txn(2'b10, 1, 8'd9, 4, 0, 0);   // R5 R6 read back across wrap
    txn(2'b10, 0, 8'd3, 3, 1, 0);   // R7 repeated writes to one register
    txn(2'b10, 1, 8'd3, 3, 1, 0);   // R7 polling
    txn(2'b11, 0, 8'd0, 3, 0, 0);   // R3 wrong strap bits
    txn(2'b10, 0, 8'd5, 1, 0, 1);   // R8 trailing half byte
    txn(2'b10, 1, 8'd2, 1, 0, 1);   // R1 fresh frame after partial
    for (int t = 0; t < 25; t++)
      txn(($urandom % 4 == 0) ? 2'($urandom) : 2'b10, 1'($urandom), 8'($urandom % 11),
          1 + $urandom % 4, 1'($urandom), 0);   // R2 random traffic
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule